// File: doc/BRIEF.md
# Segment Window Address Translator

This block is the first stage of virtual-to-physical address translation. Each valid request carries a 64-bit virtual address and the current privilege level. It also carries the direct-address and paging enables, four segment-window configuration words and a flag that selects 64-bit or 32-bit addressing. The block resolves the request in three steps:

- **Direct bypass.** Direct-address mode with paging clear takes the address through unchanged.
- **Window match.** Otherwise the four windows are tried. Each window is qualified by privilege and by a segment compare.
- **Canonical check.** A request that no window claims gets a sign-extension check.

The result appears one cycle after the request as a 2-bit code:

- **hit:** the physical address is returned with read, write and execute permission.
- **bad address:** the address fails the canonical check.
- **mapped:** the request must go on to the TLB or the page walker.

A segment window maps a whole region of virtual space onto physical space with no TLB entry. The layout of a window word depends on the mode:

- **Privilege enables.** Bit 0 enables the window for privilege level 0 (kernel). Bit 3 enables it for privilege level 3 (user).
- **64-bit mode.** The window's segment is in bits [63:60].
- **32-bit mode.** The window's segment is in bits [31:29], and its physical segment is in bits [27:25].

Top module: `segwin_xlate`

## Requirements
- R1: When `daEn`=1 and `pgEn`=0, the result is code 0 (hit), `outPaddr` = `vaddr[47:0]` zero-extended and `outPerm` = 3'b111. When `pgEn`=1 the bypass is not taken, even with `daEn`=1.
- R2: A window is eligible only under these conditions:
  - `privMode`=0 and window bit 0 is set, or
  - `privMode`=3 and window bit 3 is set.
  Privilege levels 1 and 2 match no window.
- R3: The windows are tried from index 0 to index 3, and the lowest-indexed eligible window whose segment matches decides the result.
- R4: In 64-bit mode (`is64`=1), `vaddr[63:60]` is compared with window bits [63:60]. A hit returns `vaddr[47:0]` zero-extended.
- R5: In 32-bit mode, `vaddr[31:29]` is compared with window bits [31:29]. A hit returns `{window[27:25], vaddr[28:0]}` zero-extended to 64 bits.
- R6: Every hit, whether by bypass or by window, reports `outPerm` = 3'b111 (bit 2 read, bit 1 write, bit 0 execute).
- R7: With no bypass and no window hit, if `vaddr[63:48]` is neither all zeros nor all ones, the result is code 1 (bad address) with `outPaddr`=0 and `outPerm`=0.
- R8: With no bypass and no window hit, a canonical address gives code 2 (mapped translation needed) with `outPaddr`=0 and `outPerm`=0. Code 3 never appears.
- R9: `outValid` is `inValid` delayed by one clock. When `inValid` is low, `outCode`, `outPaddr` and `outPerm` keep their last values.
- R10: During reset, `outValid`, `outCode`, `outPaddr` and `outPerm` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Request strobe |
| vaddr | input | 64 | Virtual address |
| privMode | input | 2 | Privilege level (0 kernel, 3 user) |
| daEn | input | 1 | Direct-address mode enable |
| pgEn | input | 1 | Paging enable |
| is64 | input | 1 | 1 = 64-bit addressing, 0 = 32-bit |
| winCfg0 | input | 64 | Segment window 0 configuration |
| winCfg1 | input | 64 | Segment window 1 configuration |
| winCfg2 | input | 64 | Segment window 2 configuration |
| winCfg3 | input | 64 | Segment window 3 configuration |
| outValid | output | 1 | Result strobe, one cycle after request |
| outCode | output | 2 | 0 hit, 1 bad address, 2 mapped |
| outPaddr | output | 64 | Physical address on hit, else zero |
| outPerm | output | 3 | Read/write/execute permission on hit |

## Verification
The bound checker watches these properties on every cycle:
- the one-cycle result latency and the holding of the outputs between requests;
- the tie between a hit code and full permission, and the zeroed address and permission on a non-hit;
- the absence of code 3;
- the bypass address;
- that a bad-address code only follows a non-canonical upper field.

Only the bench scenarios can show the rest:
- that the lowest-indexed window wins when several match;
- that privilege levels 1 and 2 are refused;
- that each mode reads its own segment and physical-segment positions;
- that the bypass is suppressed while paging is on.

// File: rtl/segwin_pkg.sv
package segwin_pkg;

  parameter int NUM_WIN = 4;

  typedef enum logic [1:0] {
    CODE_HIT    = 2'd0,
    CODE_BAD    = 2'd1,
    CODE_MAPPED = 2'd2
  } xlate_code_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic               load;
    logic               selDirect;
    logic [NUM_WIN-1:0] winSel;
    xlate_code_e        code;
  } ctrl_strobe_t;

endpackage

// File: rtl/segwinCtrl.sv
module segwinCtrl
  import segwin_pkg::*;
#(
  parameter int ADDR_W       = 64,
  parameter int VA_W         = 48,
  parameter int SEG64_LO     = 60,
  parameter int SEG32_LO     = 29,
  parameter int SEG32_HI     = 31,
  parameter int PLV_USER_BIT = 3
) (
  input  logic              inValid,
  input  logic [ADDR_W-1:0] vaddr,
  input  logic [1:0]        privMode,
  input  logic              daEn,
  input  logic              pgEn,
  input  logic              is64,
  input  logic [ADDR_W-1:0] winCfg [NUM_WIN],
  output ctrl_strobe_t      strobes
);

  localparam int CANON_W = 16;
  localparam int PLV_W   = PLV_USER_BIT + 1;

  logic [PLV_W-1:0]   plvVec;
  logic [NUM_WIN-1:0] winMatch;
  logic [NUM_WIN-1:0] winFirst;
  logic [CANON_W-1:0] upperBits;
  logic               canonOk;
  logic               directReq;
  logic               unusedCfg;

  always_comb begin
    plvVec = '0;
    if (privMode == 2'd0) plvVec[0] = 1'b1;
    if (privMode == 2'd3) plvVec[PLV_USER_BIT] = 1'b1;
  end

  assign directReq = daEn & ~pgEn;

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    logic privOk;
    logic segHit;
    assign privOk = |(plvVec & winCfg[i][PLV_W-1:0]);
    assign segHit = is64 ? (vaddr[ADDR_W-1:SEG64_LO] == winCfg[i][ADDR_W-1:SEG64_LO])
                         : (vaddr[SEG32_HI:SEG32_LO] == winCfg[i][SEG32_HI:SEG32_LO]);
    assign winMatch[i] = privOk & segHit;
  end

  // Lowest index wins: isolate least significant set bit
  assign winFirst = winMatch & (~winMatch + NUM_WIN'(1));

  assign upperBits = vaddr[VA_W+CANON_W-1:VA_W];
  assign canonOk   = (&upperBits) | ~(|upperBits);

  always_comb begin
    strobes.load      = inValid;
    strobes.selDirect = directReq;
    strobes.winSel    = directReq ? '0 : winFirst;
    if (directReq || (|winMatch)) strobes.code = CODE_HIT;
    else if (!canonOk)            strobes.code = CODE_BAD;
    else                          strobes.code = CODE_MAPPED;
  end

  always_comb begin
    unusedCfg = 1'b0;
    for (int i = 0; i < NUM_WIN; i++) unusedCfg = unusedCfg ^ (^winCfg[i]);
  end

endmodule

// File: rtl/segwinDatapath.sv
module segwinDatapath
  import segwin_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int VA_W     = 48,
  parameter int PA_W     = 48,
  parameter int SEG32_LO = 29,
  parameter int SEG32_HI = 31,
  parameter int PSEG_LO  = 25
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] vaddr,
  input  logic              is64,
  input  logic [ADDR_W-1:0] winCfg [NUM_WIN],
  input  ctrl_strobe_t      strobes,
  output logic [ADDR_W-1:0] outPaddr,
  output logic [1:0]        outCode,
  output logic [2:0]        outPerm,
  output logic              outValid
);

  localparam int SEG32_W = SEG32_HI - SEG32_LO + 1;
  localparam int A32_W   = SEG32_HI + 1;

  logic [ADDR_W-1:0] directPa;
  logic [ADDR_W-1:0] va64Pa;
  logic [ADDR_W-1:0] cand [NUM_WIN];
  logic [ADDR_W-1:0] nextPaddr;
  logic              isHit;
  logic              unusedIn;

  assign directPa = {{(ADDR_W-PA_W){1'b0}}, vaddr[PA_W-1:0]};
  assign va64Pa   = {{(ADDR_W-VA_W){1'b0}}, vaddr[VA_W-1:0]};

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_cand
    logic [SEG32_W-1:0] pseg;
    assign pseg    = winCfg[i][PSEG_LO+SEG32_W-1:PSEG_LO];
    assign cand[i] = is64 ? va64Pa
                          : {{(ADDR_W-A32_W){1'b0}}, pseg, vaddr[SEG32_LO-1:0]};
  end

  always_comb begin
    nextPaddr = strobes.selDirect ? directPa : '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (strobes.winSel[i]) nextPaddr = nextPaddr | cand[i];
    end
  end

  assign isHit = (strobes.code == CODE_HIT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outCode  <= 2'd0;
      outPaddr <= '0;
      outPerm  <= 3'b000;
    end else begin
      outValid <= strobes.load;
      if (strobes.load) begin
        outCode  <= strobes.code;
        outPaddr <= isHit ? nextPaddr : '0;
        outPerm  <= isHit ? 3'b111 : 3'b000;
      end
    end
  end

  always_comb begin
    unusedIn = ^vaddr;
    for (int i = 0; i < NUM_WIN; i++) unusedIn = unusedIn ^ (^winCfg[i]);
  end

endmodule

// File: rtl/segwin_xlate.sv
module segwin_xlate
  import segwin_pkg::*;
#(
  parameter int ADDR_W       = 64,
  parameter int VA_W         = 48,
  parameter int PA_W         = 48,
  parameter int SEG64_LO     = 60,
  parameter int SEG32_LO     = 29,
  parameter int SEG32_HI     = 31,
  parameter int PSEG_LO      = 25,
  parameter int PLV_USER_BIT = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [ADDR_W-1:0] vaddr,
  input  logic [1:0]        privMode,
  input  logic              daEn,
  input  logic              pgEn,
  input  logic              is64,
  input  logic [ADDR_W-1:0] winCfg0,
  input  logic [ADDR_W-1:0] winCfg1,
  input  logic [ADDR_W-1:0] winCfg2,
  input  logic [ADDR_W-1:0] winCfg3,
  output logic              outValid,
  output logic [1:0]        outCode,
  output logic [ADDR_W-1:0] outPaddr,
  output logic [2:0]        outPerm
);

  logic [ADDR_W-1:0] winArr [NUM_WIN];
  ctrl_strobe_t      strobes;

  assign winArr[0] = winCfg0;
  assign winArr[1] = winCfg1;
  assign winArr[2] = winCfg2;
  assign winArr[3] = winCfg3;

  segwinCtrl #(
    .ADDR_W(ADDR_W), .VA_W(VA_W), .SEG64_LO(SEG64_LO), .SEG32_LO(SEG32_LO),
    .SEG32_HI(SEG32_HI), .PLV_USER_BIT(PLV_USER_BIT)
  ) u_ctrl (
    .inValid (inValid),
    .vaddr   (vaddr),
    .privMode(privMode),
    .daEn    (daEn),
    .pgEn    (pgEn),
    .is64    (is64),
    .winCfg  (winArr),
    .strobes (strobes)
  );

  segwinDatapath #(
    .ADDR_W(ADDR_W), .VA_W(VA_W), .PA_W(PA_W), .SEG32_LO(SEG32_LO),
    .SEG32_HI(SEG32_HI), .PSEG_LO(PSEG_LO)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .vaddr   (vaddr),
    .is64    (is64),
    .winCfg  (winArr),
    .strobes (strobes),
    .outPaddr(outPaddr),
    .outCode (outCode),
    .outPerm (outPerm),
    .outValid(outValid)
  );

endmodule

// File: rtl/segwin_xlate_chk.sv
module segwin_xlate_chk #(
  parameter int ADDR_W = 64,
  parameter int VA_W   = 48,
  parameter int PA_W   = 48
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [ADDR_W-1:0] vaddr,
  input logic              daEn,
  input logic              pgEn,
  input logic              outValid,
  input logic [1:0]        outCode,
  input logic [ADDR_W-1:0] outPaddr,
  input logic [2:0]        outPerm
);

  logic        afterRst;
  logic [15:0] upperBits;
  logic        unusedChk;

  assign upperBits = vaddr[VA_W+15:VA_W];
  assign unusedChk = ^vaddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) afterRst <= 1'b0;
    else       afterRst <= 1'b1;
  end

  // R9
  valid_lat_chk: assert property (@(posedge clk) disable iff (!rstN)
    afterRst |-> (outValid == $past(inValid)));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (afterRst && !$past(inValid)) |-> ($stable(outPaddr) && $stable(outCode) && $stable(outPerm)));

  // R6
  hit_perm_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outCode == 2'd0) |-> (outPerm == 3'b111));

  // R8
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outCode != 2'd0) |-> (outPerm == 3'b000 && outPaddr == '0));

  // R8
  code_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    outCode != 2'd3);

  // R1
  direct_chk: assert property (@(posedge clk) disable iff (!rstN)
    (afterRst && $past(inValid && daEn && !pgEn)) |->
      (outCode == 2'd0 && outPaddr == {{(ADDR_W-PA_W){1'b0}}, $past(vaddr[PA_W-1:0])}));

  // R7
  bad_chk: assert property (@(posedge clk) disable iff (!rstN)
    (afterRst && $past(inValid) && outCode == 2'd1) |->
      ($past(upperBits) != 16'h0000 && $past(upperBits) != 16'hFFFF));

endmodule

bind segwin_xlate segwin_xlate_chk #(.ADDR_W(ADDR_W), .VA_W(VA_W), .PA_W(PA_W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .vaddr(vaddr), .daEn(daEn), .pgEn(pgEn),
  .outValid(outValid), .outCode(outCode), .outPaddr(outPaddr), .outPerm(outPerm)
);

// File: tb/segwin_xlate_tb.sv
module segwin_xlate_tb;

  typedef struct {
    logic [1:0]  code;
    logic [63:0] paddr;
    logic [2:0]  perm;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [63:0] vaddr = '0;
  logic [1:0]  privMode = 2'd0;
  logic        daEn = 1'b0, pgEn = 1'b1, is64 = 1'b1;
  logic [63:0] winCfg0 = '0, winCfg1 = '0, winCfg2 = '0, winCfg3 = '0;
  logic        outValid;
  logic [1:0]  outCode;
  logic [63:0] outPaddr;
  logic [2:0]  outPerm;

  int   nCmp = 0;
  int   nBad = 0;
  exp_t sbq[$];
  exp_t lastExp;

  always #2.5 clk = ~clk;

  segwin_xlate u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .vaddr(vaddr), .privMode(privMode),
    .daEn(daEn), .pgEn(pgEn), .is64(is64), .winCfg0(winCfg0), .winCfg1(winCfg1),
    .winCfg2(winCfg2), .winCfg3(winCfg3), .outValid(outValid), .outCode(outCode),
    .outPaddr(outPaddr), .outPerm(outPerm)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference model written from the requirements
  function automatic exp_t model(input logic [63:0] va, input logic [1:0] pm,
                                 input logic da, input logic pg, input logic m64);
    exp_t e;
    logic [63:0] w [4];
    w[0] = winCfg0; w[1] = winCfg1; w[2] = winCfg2; w[3] = winCfg3;
    e.code = 2'd2; e.paddr = '0; e.perm = 3'b000; e.tag = "";
    if (da && !pg) begin
      e.code = 2'd0; e.paddr = {16'h0, va[47:0]}; e.perm = 3'b111;
      return e;
    end
    for (int i = 0; i < 4; i++) begin
      bit pOk, sOk;
      pOk = (pm == 2'd0 && w[i][0]) || (pm == 2'd3 && w[i][3]);
      sOk = m64 ? (va[63:60] == w[i][63:60]) : (va[31:29] == w[i][31:29]);
      if (pOk && sOk) begin
        e.code = 2'd0; e.perm = 3'b111;
        e.paddr = m64 ? {16'h0, va[47:0]} : {32'h0, w[i][27:25], va[28:0]};
        return e;
      end
    end
    if (va[63:48] != 16'h0000 && va[63:48] != 16'hFFFF) e.code = 2'd1;
    return e;
  endfunction

  task automatic drive(input logic [63:0] va, input logic [1:0] pm, input logic da,
                       input logic pg, input logic m64, input string tag);
    exp_t e;
    @(negedge clk);
    vaddr = va; privMode = pm; daEn = da; pgEn = pg; is64 = m64; inValid = 1'b1;
    e = model(va, pm, da, pg, m64);
    e.tag = tag;
    sbq.push_back(e);
    lastExp = e;
  endtask

  // Monitor: pops and compares
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rstN && outValid) begin
        exp_t e;
        if (sbq.size() == 0) begin
          check(1'b0, "R9 unexpected outValid", 64'(outValid), 64'd0);
        end else begin
          e = sbq.pop_front();
          check(outCode == e.code, {e.tag, " code"}, 64'(outCode), 64'(e.code));
          check(outPaddr == e.paddr, {e.tag, " paddr"}, outPaddr, e.paddr);
          check(outPerm == e.perm, {e.tag, " perm"}, 64'(outPerm), 64'(e.perm));
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog expired", 64'd0, 64'd1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(outValid == 1'b0 && outCode == 2'd0 && outPaddr == '0 && outPerm == 3'b000,
          "R10 reset state", {outPaddr[58:0], outPerm, outCode}, 64'd0);
    @(negedge clk);
    rstN = 1'b1;

    // 64-bit windows: win0 kernel seg 9, win1 user seg A
    winCfg0 = {4'h9, 56'h0, 4'b0001};
    winCfg1 = {4'hA, 56'h0, 4'b1000};
    winCfg2 = '0;
    winCfg3 = '0;
    drive(64'hFFFF_1234_5678_9ABC, 2'd3, 1'b1, 1'b0, 1'b1, "R1 direct bypass");
    drive(64'h0000_0000_0000_1000, 2'd0, 1'b1, 1'b1, 1'b1, "R1 bypass off with paging");
    drive(64'h9000_1234_5678_9ABC, 2'd0, 1'b0, 1'b1, 1'b1, "R4 kernel 64b hit");
    drive(64'h9000_1234_5678_9ABC, 2'd3, 1'b0, 1'b1, 1'b1, "R2 user refused by kernel window");
    drive(64'hA000_0000_0000_0042, 2'd3, 1'b0, 1'b1, 1'b1, "R2 user window hit");
    drive(64'hA000_0000_0000_0042, 2'd1, 1'b0, 1'b1, 1'b1, "R2 level 1 refused");
    drive(64'hFFFF_8000_0000_0000, 2'd0, 1'b0, 1'b1, 1'b1, "R8 canonical high mapped");
    drive(64'h0000_7FFF_FFFF_F000, 2'd0, 1'b0, 1'b1, 1'b1, "R8 canonical low mapped");
    drive(64'h0001_0000_0000_0000, 2'd0, 1'b0, 1'b1, 1'b1, "R7 non-canonical");
    drive(64'h9000_0000_0000_0000, 2'd2, 1'b0, 1'b1, 1'b1, "R7 level 2 non-canonical");

    // 32-bit windows: win1 and win2 both seg 101, different psegs
    @(negedge clk);
    inValid = 1'b0;
    winCfg0 = {32'h0, 3'b011, 1'b0, 3'b111, 21'h0, 4'b0001};
    winCfg1 = {32'h0, 3'b101, 1'b0, 3'b010, 21'h0, 4'b0001};
    winCfg2 = {32'h0, 3'b101, 1'b0, 3'b110, 21'h0, 4'b1001};
    winCfg3 = '0;
    drive(64'h0000_0000_A000_1234, 2'd0, 1'b0, 1'b1, 1'b0, "R3 R5 lowest window wins");
    drive(64'h0000_0000_A000_1234, 2'd3, 1'b0, 1'b1, 1'b0, "R3 R5 user falls to window 2");
    drive(64'h0000_0000_6ABC_DEF0, 2'd0, 1'b0, 1'b1, 1'b0, "R5 32b window 0");
    drive(64'h0000_0000_2000_0000, 2'd0, 1'b0, 1'b1, 1'b0, "R8 32b no window");
    @(negedge clk);
    inValid = 1'b0;
    winCfg1 = {32'h0, 3'b101, 1'b0, 3'b010, 21'h0, 4'b0000};
    drive(64'h0000_0000_A000_1234, 2'd0, 1'b0, 1'b1, 1'b0, "R3 disabled window skipped");

    // Mixed patterns through the model
    for (int k = 0; k < 200; k++) begin
      logic [63:0] va;
      va = {$urandom, $urandom};
      if (k % 3 == 0) va[63:48] = (k % 2 == 0) ? 16'h0 : 16'hFFFF;
      if (k % 5 == 0) va[63:60] = 4'h9;
      drive(va, 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
            "R6 mixed pattern");
    end

    // Hold between requests
    @(negedge clk);
    inValid = 1'b0;
    vaddr = 64'h0123_4567_89AB_CDEF;
    daEn = 1'b1;
    pgEn = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check(outValid == 1'b0, "R9 valid drops", 64'(outValid), 64'd0);
    check(outPaddr == lastExp.paddr && outCode == lastExp.code,
          "R9 outputs hold", outPaddr, lastExp.paddr);
    check(sbq.size() == 0, "R9 all results seen", 64'(sbq.size()), 64'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule